// File: doc/BRIEF.md
# Completion Interrupt Moderation Controller

This block decides, for one completion ring, when to raise an interrupt and when to ask for a completion status write. User logic reports every completion entry it writes and may also ask for an interrupt directly. Software reports how far it has read the ring by sending a consumer-index update. Each update also re-arms the moderation logic. Thresholds for the moderation timer and for the event counter come from two small banks of registers, and the per-queue context selects an entry in each bank by index.

The controller has two arming states. In the idle state (`arm_state` = 0) it ignores every trigger source. A consumer-index update moves it to the armed state (`arm_state` = 1). In the armed state the programmed trigger mode decides what causes a firing. A firing produces a one-cycle request on `irq_req` and/or `stat_req`, depending on the two enables, and returns the controller to the idle state. If user logic asks for an interrupt while the controller is idle, the request is remembered. It is then honoured at the next consumer-index update, but only if the ring still holds unread entries. A full-update flag decides whether an update may also rewrite the moderation configuration, or only the consumer index.

Top module: `cmpl_irq_moderator`

## Requirements
- R1: After reset: `arm_state`, `irq_req`, `stat_req`, `timer_running` and `user_trig_pend` are 0. `pidx`, `cidx` and `trig_mode` are 0. `irq_en` and `stat_en` are 0.
- R2: While `arm_state` is 0 and no update is presented, `cmpl_evt` and `user_trig` produce no request in the following cycle.
- R3: A consumer-index update sets `arm_state` to 1 in the next cycle, unless that same update causes a firing.
- R4: In trigger mode 1 (every entry), each `cmpl_evt` seen while armed produces a request in the next cycle.
- R5: In trigger mode 3 (user only), `user_trig` fires while armed and `cmpl_evt` does not.
- R6: In trigger mode 2 (user or count), the Nth armed `cmpl_evt` fires. N is the count bank entry chosen by `cnt_sel`, and a stored 0 acts as 1. `user_trig` also fires. Every firing clears the event count.
- R7: In trigger mode 4 (user or timer), the first armed `cmpl_evt` starts the timer and `timer_running` goes to 1. For a timer bank value T (0 acts as 1), the request appears T+1 cycles after that event. `user_trig` also fires.
- R8: In trigger mode 5 (user, timer or count), whichever comes first, the count threshold or the timer expiry, causes the firing.
- R9: In trigger mode 0 (off), and in codes 6 and 7, nothing fires.
- R10: In the cycle a request is shown, `arm_state` and `timer_running` are both 0.
- R11: A `user_trig` seen while idle, outside an update cycle, sets `user_trig_pend`. Every update clears it. The update fires if the bit was set and the new consumer index differs from `pidx`.
- R12: With `ctx_full_upd` = 0, an update changes only `cidx`. With `ctx_full_upd` = 1, it also loads the trigger mode, both selects and both enables.
- R13: `irq_req` is raised only when `irq_en` is 1, and `stat_req` only when `stat_en` is 1. Each follows its own enable, independently of the other.
- R14: `pidx` advances by one, modulo 2^IDX_W, on each `cmpl_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr_en | input | 1 | Threshold register write strobe |
| thr_wr_cnt_bank | input | 1 | 1 writes the count bank, 0 writes the timer bank |
| thr_wr_sel | input | SEL_W | Threshold register index |
| thr_wr_data | input | THR_W | Threshold value |
| ctx_full_upd | input | 1 | Updates may also rewrite the configuration |
| cidx_upd_vld | input | 1 | Software consumer-index update strobe |
| cidx_upd_val | input | IDX_W | New consumer index |
| upd_trig_mode | input | 3 | Trigger mode carried by the update |
| upd_tmr_sel | input | SEL_W | Timer bank index carried by the update |
| upd_cnt_sel | input | SEL_W | Count bank index carried by the update |
| upd_irq_en | input | 1 | Interrupt enable carried by the update |
| upd_stat_en | input | 1 | Status-write enable carried by the update |
| cmpl_evt | input | 1 | One completion entry written |
| user_trig | input | 1 | User logic interrupt request |
| irq_req | output | 1 | Interrupt request pulse |
| stat_req | output | 1 | Status-write request pulse |
| arm_state | output | 1 | 0 idle, 1 armed |
| timer_running | output | 1 | Moderation timer active |
| user_trig_pend | output | 1 | Latched user request waiting for an update |
| pidx | output | IDX_W | Producer index |
| cidx | output | IDX_W | Consumer index copy |
| trig_mode | output | 3 | Current trigger mode |
| tmr_sel | output | SEL_W | Current timer bank index |
| cnt_sel | output | SEL_W | Current count bank index |
| irq_en | output | 1 | Current interrupt enable |
| stat_en | output | 1 | Current status-write enable |

## Verification
Each firing is registered once. A request caused by an event or trigger in one cycle is therefore visible in the next cycle, together with the return to the idle state. A request caused by an update is visible in the cycle after the update. The one exception is the timer path. With threshold T, the request lags the starting event by T+1 cycles, and `timer_running` is high for exactly the T cycles before it. The bench drives on the falling edge, then samples after the single rising edge that should produce the result. For the timer and count sweeps, it checks that the output stays quiet at every earlier sample point.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

  typedef enum logic [2:0] {
    TM_OFF     = 3'd0,
    TM_EVERY   = 3'd1,
    TM_UCOUNT  = 3'd2,
    TM_USER    = 3'd3,
    TM_UTIMER  = 3'd4,
    TM_UTCOUNT = 3'd5
  } trig_mode_e;

  typedef enum logic {
    ARM_IDLE  = 1'b0,
    ARM_READY = 1'b1
  } arm_state_e;

  function automatic logic mode_active(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd5);
  endfunction

  function automatic logic mode_uses_count(input logic [2:0] m);
    return (m == 3'(TM_UCOUNT)) || (m == 3'(TM_UTCOUNT));
  endfunction

  function automatic logic mode_uses_timer(input logic [2:0] m);
    return (m == 3'(TM_UTIMER)) || (m == 3'(TM_UTCOUNT));
  endfunction

  function automatic logic mode_takes_user(input logic [2:0] m);
    return (m >= 3'd2) && (m <= 3'd5);
  endfunction

endpackage

// File: rtl/cirq_thr_bank.sv
module cirq_thr_bank #(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_cnt_bank,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [THR_W-1:0] wr_data,
  input  logic [SEL_W-1:0] tmr_rd_sel,
  input  logic [SEL_W-1:0] cnt_rd_sel,
  output logic [THR_W-1:0] tmr_rd_data,
  output logic [THR_W-1:0] cnt_rd_data
);
  localparam int unsigned DEPTH = 1 << SEL_W;
  localparam int unsigned NBANK = 2;

  logic [SEL_W-1:0] rd_sel  [NBANK];
  logic [THR_W-1:0] rd_data [NBANK];

  assign rd_sel[0]   = tmr_rd_sel;
  assign rd_sel[1]   = cnt_rd_sel;
  assign tmr_rd_data = rd_data[0];
  assign cnt_rd_data = rd_data[1];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [THR_W-1:0] regs_q [DEPTH];
    logic             hit;

    assign hit = wr_en && (wr_cnt_bank == 1'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
      end else if (hit) begin
        regs_q[wr_sel] <= wr_data;
      end
    end

    assign rd_data[b] = regs_q[rd_sel[b]];
  end

endmodule

// File: rtl/cirq_evt_count.sv
module cirq_evt_count #(
  parameter int unsigned THR_W = 8,
  parameter int unsigned CNT_W = THR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);
  localparam int unsigned EW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EW-1:0]    cnt_plus;
  logic [EW-1:0]    thr_eff;

  function automatic logic [EW-1:0] eff_limit(input logic [THR_W-1:0] t);
    return (t == '0) ? EW'(1) : EW'(t);
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == '1) ? c : c + CNT_W'(1);
  endfunction

  assign cnt_plus = EW'(cnt_q) + EW'(1);
  assign thr_eff  = eff_limit(thr);
  assign hit      = inc && (cnt_plus >= thr_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= sat_inc(cnt_q);
  end

  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/cirq_mod_timer.sv
module cirq_mod_timer #(
  parameter int unsigned THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clr,
  input  logic [THR_W-1:0] thr,
  output logic             running,
  output logic             expire
);
  localparam int unsigned EW = THR_W + 1;

  logic [THR_W-1:0] elapsed_q;
  logic             run_q;
  logic [EW-1:0]    elapsed_plus;
  logic [EW-1:0]    thr_eff;

  function automatic logic [EW-1:0] eff_limit(input logic [THR_W-1:0] t);
    return (t == '0) ? EW'(1) : EW'(t);
  endfunction

  assign elapsed_plus = EW'(elapsed_q) + EW'(1);
  assign thr_eff      = eff_limit(thr);
  assign expire       = run_q && (elapsed_plus >= thr_eff);
  assign running      = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      elapsed_q <= '0;
    end else if (clr) begin
      run_q     <= 1'b0;
      elapsed_q <= '0;
    end else if (start) begin
      run_q     <= 1'b1;
      elapsed_q <= '0;
    end else if (run_q && (elapsed_q != '1)) begin
      elapsed_q <= elapsed_q + THR_W'(1);
    end
  end

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (elapsed_q == '0));

  // R7
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr) |=> run_q);

endmodule

// File: rtl/cmpl_irq_moderator.sv
module cmpl_irq_moderator
  import cirq_pkg::*;
#(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr_en,
  input  logic             thr_wr_cnt_bank,
  input  logic [SEL_W-1:0] thr_wr_sel,
  input  logic [THR_W-1:0] thr_wr_data,
  input  logic             ctx_full_upd,
  input  logic             cidx_upd_vld,
  input  logic [IDX_W-1:0] cidx_upd_val,
  input  logic [2:0]       upd_trig_mode,
  input  logic [SEL_W-1:0] upd_tmr_sel,
  input  logic [SEL_W-1:0] upd_cnt_sel,
  input  logic             upd_irq_en,
  input  logic             upd_stat_en,
  input  logic             cmpl_evt,
  input  logic             user_trig,
  output logic             irq_req,
  output logic             stat_req,
  output logic             arm_state,
  output logic             timer_running,
  output logic             user_trig_pend,
  output logic [IDX_W-1:0] pidx,
  output logic [IDX_W-1:0] cidx,
  output logic [2:0]       trig_mode,
  output logic [SEL_W-1:0] tmr_sel,
  output logic [SEL_W-1:0] cnt_sel,
  output logic             irq_en,
  output logic             stat_en
);
  localparam int unsigned CNT_W = THR_W + 1;

  // context registers
  arm_state_e       arm_q;
  logic             pend_q;
  logic [IDX_W-1:0] pidx_q, cidx_q;
  logic [2:0]       mode_q;
  logic [SEL_W-1:0] tsel_q, csel_q;
  logic             ien_q, sen_q;
  logic             irq_q, stat_q;

  // configuration as it will stand after this cycle
  logic             cfg_apply;
  logic [2:0]       mode_nx;
  logic [SEL_W-1:0] tsel_nx, csel_nx;
  logic             ien_nx, sen_nx;

  // named internal events
  logic             eval_ok;
  logic             every_hit, user_hit, cnt_inc, cnt_hit;
  logic             tmr_start, tmr_clr, tmr_exp, tmr_hit, tmr_run;
  logic             cnt_clr;
  logic             ring_unread, pend_fire, trig_fire, fire;
  logic [THR_W-1:0] tmr_thr, cnt_thr;

  assign cfg_apply = cidx_upd_vld && ctx_full_upd;
  assign mode_nx   = cfg_apply ? upd_trig_mode : mode_q;
  assign tsel_nx   = cfg_apply ? upd_tmr_sel   : tsel_q;
  assign csel_nx   = cfg_apply ? upd_cnt_sel   : csel_q;
  assign ien_nx    = cfg_apply ? upd_irq_en    : ien_q;
  assign sen_nx    = cfg_apply ? upd_stat_en   : sen_q;

  cirq_thr_bank #(.SEL_W(SEL_W), .THR_W(THR_W)) u_thr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (thr_wr_en),
    .wr_cnt_bank (thr_wr_cnt_bank),
    .wr_sel      (thr_wr_sel),
    .wr_data     (thr_wr_data),
    .tmr_rd_sel  (tsel_q),
    .cnt_rd_sel  (csel_q),
    .tmr_rd_data (tmr_thr),
    .cnt_rd_data (cnt_thr)
  );

  // trigger evaluation only while armed and outside update cycles
  assign eval_ok   = (arm_q == ARM_READY) && !cidx_upd_vld &&
                     mode_active(mode_q) && (ien_q || sen_q);
  assign every_hit = eval_ok && (mode_q == 3'(TM_EVERY)) && cmpl_evt;
  assign user_hit  = eval_ok && mode_takes_user(mode_q) && user_trig;
  assign cnt_inc   = eval_ok && mode_uses_count(mode_q) && cmpl_evt;
  assign tmr_hit   = eval_ok && mode_uses_timer(mode_q) && tmr_exp;
  assign trig_fire = every_hit || user_hit || cnt_hit || tmr_hit;

  assign ring_unread = (cidx_upd_val != pidx_q);
  assign pend_fire   = cidx_upd_vld && pend_q && ring_unread &&
                       mode_active(mode_nx) && (ien_nx || sen_nx);
  assign fire        = trig_fire || pend_fire;

  assign tmr_start = eval_ok && mode_uses_timer(mode_q) && cmpl_evt &&
                     !tmr_run && !trig_fire;
  assign tmr_clr   = fire || cfg_apply || tmr_exp;
  assign cnt_clr   = fire || cfg_apply;

  cirq_evt_count #(.THR_W(THR_W), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (cnt_inc),
    .clr   (cnt_clr),
    .thr   (cnt_thr),
    .hit   (cnt_hit)
  );

  cirq_mod_timer #(.THR_W(THR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .clr     (tmr_clr),
    .thr     (tmr_thr),
    .running (tmr_run),
    .expire  (tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= ARM_IDLE;
      pend_q <= 1'b0;
      pidx_q <= '0;
      cidx_q <= '0;
      mode_q <= 3'(TM_OFF);
      tsel_q <= '0;
      csel_q <= '0;
      ien_q  <= 1'b0;
      sen_q  <= 1'b0;
      irq_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (fire)              arm_q <= ARM_IDLE;
      else if (cidx_upd_vld) arm_q <= ARM_READY;

      if (cidx_upd_vld)                          pend_q <= 1'b0;
      else if (user_trig && (arm_q == ARM_IDLE)) pend_q <= 1'b1;

      if (cmpl_evt)     pidx_q <= pidx_q + IDX_W'(1);
      if (cidx_upd_vld) cidx_q <= cidx_upd_val;

      mode_q <= mode_nx;
      tsel_q <= tsel_nx;
      csel_q <= csel_nx;
      ien_q  <= ien_nx;
      sen_q  <= sen_nx;

      irq_q  <= fire && ien_nx;
      stat_q <= fire && sen_nx;
    end
  end

  assign irq_req        = irq_q;
  assign stat_req       = stat_q;
  assign arm_state      = arm_q;
  assign timer_running  = tmr_run;
  assign user_trig_pend = pend_q;
  assign pidx           = pidx_q;
  assign cidx           = cidx_q;
  assign trig_mode      = mode_q;
  assign tmr_sel        = tsel_q;
  assign cnt_sel        = csel_q;
  assign irq_en         = ien_q;
  assign stat_en        = sen_q;

  // R2
  isr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_state && !cidx_upd_vld) |=> !(irq_req || stat_req));

  // R3
  arm_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cidx_upd_vld |=> (arm_state || irq_req || stat_req));

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_active(trig_mode) && !cidx_upd_vld) |=> !(irq_req || stat_req));

  // R10
  disarm_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req || stat_req) |-> (!arm_state && !timer_running));

  // R11
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cidx_upd_vld |=> !user_trig_pend);

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cidx_upd_vld && !ctx_full_upd) |=>
      ($stable(trig_mode) && $stable(tmr_sel) && $stable(cnt_sel) &&
       $stable(irq_en) && $stable(stat_en)));

  // R13
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_en);

  // R13
  stat_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_req |-> stat_en);

  // R14
  pidx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_evt |=> (pidx == $past(pidx) + IDX_W'(1)));

endmodule

// File: tb/test_cmpl_irq_moderator.sv
module test_cmpl_irq_moderator;
  localparam int unsigned IDX_W = 16;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned THR_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             thr_wr_en, thr_wr_cnt_bank;
  logic [SEL_W-1:0] thr_wr_sel;
  logic [THR_W-1:0] thr_wr_data;
  logic             ctx_full_upd, cidx_upd_vld;
  logic [IDX_W-1:0] cidx_upd_val;
  logic [2:0]       upd_trig_mode;
  logic [SEL_W-1:0] upd_tmr_sel, upd_cnt_sel;
  logic             upd_irq_en, upd_stat_en, cmpl_evt, user_trig;
  logic             irq_req, stat_req, arm_state, timer_running, user_trig_pend;
  logic [IDX_W-1:0] pidx, cidx;
  logic [2:0]       trig_mode;
  logic [SEL_W-1:0] tmr_sel, cnt_sel;
  logic             irq_en, stat_en;

  int n_vec = 0;
  int n_bad = 0;
  logic [IDX_W-1:0] exp_pidx = '0;

  always #4 clk = ~clk;

  cmpl_irq_moderator #(.IDX_W(IDX_W), .SEL_W(SEL_W), .THR_W(THR_W)) i_cmpl_irq_moderator (
    .clk(clk), .rst_n(rst_n),
    .thr_wr_en(thr_wr_en), .thr_wr_cnt_bank(thr_wr_cnt_bank),
    .thr_wr_sel(thr_wr_sel), .thr_wr_data(thr_wr_data),
    .ctx_full_upd(ctx_full_upd), .cidx_upd_vld(cidx_upd_vld),
    .cidx_upd_val(cidx_upd_val), .upd_trig_mode(upd_trig_mode),
    .upd_tmr_sel(upd_tmr_sel), .upd_cnt_sel(upd_cnt_sel),
    .upd_irq_en(upd_irq_en), .upd_stat_en(upd_stat_en),
    .cmpl_evt(cmpl_evt), .user_trig(user_trig),
    .irq_req(irq_req), .stat_req(stat_req), .arm_state(arm_state),
    .timer_running(timer_running), .user_trig_pend(user_trig_pend),
    .pidx(pidx), .cidx(cidx), .trig_mode(trig_mode),
    .tmr_sel(tmr_sel), .cnt_sel(cnt_sel), .irq_en(irq_en), .stat_en(stat_en)
  );

  // bench view of the threshold banks: count sel k holds k, timer sel k holds k+1
  function automatic int cnt_limit(input int k);
    return (k == 0) ? 1 : k;
  endfunction

  function automatic int tmr_limit(input int k);
    return k + 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic upd(input logic [IDX_W-1:0] c, input logic full, input logic [2:0] m,
                     input int ts, input int cs, input logic ie, input logic se);
    ctx_full_upd  = full;
    cidx_upd_vld  = 1'b1;
    cidx_upd_val  = c;
    upd_trig_mode = m;
    upd_tmr_sel   = SEL_W'(ts);
    upd_cnt_sel   = SEL_W'(cs);
    upd_irq_en    = ie;
    upd_stat_en   = se;
    cyc();
    cidx_upd_vld  = 1'b0;
  endtask

  task automatic arm(input logic [2:0] m, input int ts, input int cs,
                     input logic ie, input logic se);
    upd(exp_pidx, 1'b1, m, ts, cs, ie, se);
  endtask

  task automatic evt();
    cmpl_evt = 1'b1;
    cyc();
    cmpl_evt = 1'b0;
    exp_pidx = exp_pidx + IDX_W'(1);
  endtask

  task automatic utrig();
    user_trig = 1'b1;
    cyc();
    user_trig = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    thr_wr_en = 1'b0; thr_wr_cnt_bank = 1'b0; thr_wr_sel = '0; thr_wr_data = '0;
    ctx_full_upd = 1'b0; cidx_upd_vld = 1'b0; cidx_upd_val = '0;
    upd_trig_mode = '0; upd_tmr_sel = '0; upd_cnt_sel = '0;
    upd_irq_en = 1'b0; upd_stat_en = 1'b0; cmpl_evt = 1'b0; user_trig = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk("R1 arm", 32'(arm_state), 0);
    chk("R1 irq", 32'(irq_req), 0);
    chk("R1 stat", 32'(stat_req), 0);
    chk("R1 timer", 32'(timer_running), 0);
    chk("R1 pend", 32'(user_trig_pend), 0);
    chk("R1 pidx", 32'(pidx), 0);
    chk("R1 cidx", 32'(cidx), 0);
    chk("R1 mode", 32'(trig_mode), 0);
    chk("R1 enables", 32'({irq_en, stat_en}), 0);

    // load threshold banks
    for (int k = 0; k < 16; k++) begin
      thr_wr_en = 1'b1; thr_wr_sel = SEL_W'(k);
      thr_wr_cnt_bank = 1'b1; thr_wr_data = THR_W'(k);
      cyc();
      thr_wr_cnt_bank = 1'b0; thr_wr_data = THR_W'(tmr_limit(k));
      cyc();
    end
    thr_wr_en = 1'b0;

    // R2: idle after reset ignores triggers
    evt();
    chk("R2 evt idle irq", 32'(irq_req), 0);
    chk("R14 pidx", 32'(pidx), 32'(exp_pidx));

    // R4 / R3 / R10 every-entry mode
    arm(3'd1, 0, 0, 1'b1, 1'b0);
    chk("R3 armed", 32'(arm_state), 1);
    chk("R12 full load mode", 32'(trig_mode), 1);
    for (int r = 0; r < 3; r++) begin
      evt();
      chk("R4 every irq", 32'(irq_req), 1);
      chk("R10 disarmed", 32'(arm_state), 0);
      evt();
      chk("R2 idle evt", 32'(irq_req), 0);
      upd(exp_pidx, 1'b0, 3'd0, 0, 0, 1'b0, 1'b0);
      chk("R3 rearm", 32'(arm_state), 1);
    end

    // R11 pending user trigger, ring drained: no firing
    evt();
    utrig();
    chk("R2 utrig idle irq", 32'(irq_req), 0);
    chk("R11 pend set", 32'(user_trig_pend), 1);
    upd(exp_pidx, 1'b0, 3'd0, 0, 0, 1'b0, 1'b0);
    chk("R11 drained no irq", 32'(irq_req), 0);
    chk("R11 pend clear", 32'(user_trig_pend), 0);
    chk("R11 armed", 32'(arm_state), 1);
    // R11 pending with unread entries: fires on update
    evt();
    utrig();
    upd(exp_pidx - IDX_W'(1), 1'b0, 3'd0, 0, 0, 1'b0, 1'b0);
    chk("R11 unread irq", 32'(irq_req), 1);
    chk("R11 stays idle", 32'(arm_state), 0);
    chk("R11 pend clear2", 32'(user_trig_pend), 0);

    // R12 partial update keeps configuration
    upd(exp_pidx - IDX_W'(1), 1'b0, 3'd3, 5, 7, 1'b0, 1'b1);
    chk("R12 cidx", 32'(cidx), 32'(exp_pidx - IDX_W'(1)));
    chk("R12 mode kept", 32'(trig_mode), 1);
    chk("R12 tsel kept", 32'(tmr_sel), 0);
    chk("R12 csel kept", 32'(cnt_sel), 0);
    chk("R12 en kept", 32'({irq_en, stat_en}), 32'(2'b10));
    upd(exp_pidx, 1'b1, 3'd3, 5, 7, 1'b0, 1'b1);
    chk("R12 full mode", 32'(trig_mode), 3);
    chk("R12 full sel", 32'({tmr_sel, cnt_sel}), 32'({4'd5, 4'd7}));
    chk("R12 full en", 32'({irq_en, stat_en}), 32'(2'b01));

    // R5 user-only mode
    arm(3'd3, 0, 0, 1'b1, 1'b0);
    evt();
    chk("R5 evt ignored", 32'(irq_req), 0);
    chk("R5 still armed", 32'(arm_state), 1);
    utrig();
    chk("R5 user irq", 32'(irq_req), 1);

    // R9 off mode and unused codes
    for (int m = 0; m < 8; m += 6) begin
      for (int m2 = m; m2 < m + 2 && m2 < 8; m2++) begin
        if (m2 == 1) continue;
        arm(3'(m2), 0, 0, 1'b1, 1'b1);
        evt();
        utrig();
        chk("R9 quiet", 32'({irq_req, stat_req}), 0);
        chk("R9 armed", 32'(arm_state), 1);
      end
    end

    // R13 independent enables
    arm(3'd1, 0, 0, 1'b0, 1'b1);
    evt();
    chk("R13 stat only", 32'({irq_req, stat_req}), 32'(2'b01));
    arm(3'd1, 0, 0, 1'b1, 1'b1);
    evt();
    chk("R13 both", 32'({irq_req, stat_req}), 32'(2'b11));
    arm(3'd1, 0, 0, 1'b0, 1'b0);
    evt();
    chk("R13 none", 32'({irq_req, stat_req}), 0);
    chk("R13 none armed", 32'(arm_state), 1);

    // R6 count threshold sweep
    for (int k = 0; k < 7; k++) begin
      arm(3'd2, 0, k, 1'b1, 1'b0);
      for (int j = 1; j < cnt_limit(k); j++) begin
        evt();
        chk("R6 below thr", 32'(irq_req), 0);
      end
      evt();
      chk("R6 at thr", 32'(irq_req), 1);
    end
    // R6 user fires and clears count
    arm(3'd2, 0, 3, 1'b1, 1'b0);
    evt();
    evt();
    utrig();
    chk("R6 user irq", 32'(irq_req), 1);
    upd(exp_pidx, 1'b0, 3'd0, 0, 0, 1'b0, 1'b0);
    evt();
    evt();
    chk("R6 count cleared", 32'(irq_req), 0);
    evt();
    chk("R6 recount", 32'(irq_req), 1);

    // R7 timer sweep
    for (int k = 0; k < 5; k++) begin
      arm(3'd4, k, 0, 1'b1, 1'b0);
      evt();
      for (int i = 0; i < tmr_limit(k); i++) begin
        chk("R7 running", 32'(timer_running), 1);
        chk("R7 not yet", 32'(irq_req), 0);
        cyc();
      end
      chk("R7 expiry irq", 32'(irq_req), 1);
      chk("R10 timer stopped", 32'(timer_running), 0);
    end
    arm(3'd4, 9, 0, 1'b1, 1'b0);
    evt();
    utrig();
    chk("R7 user irq", 32'(irq_req), 1);

    // R8 count wins
    arm(3'd5, 9, 3, 1'b1, 1'b0);
    evt();
    evt();
    chk("R8 count pending", 32'(irq_req), 0);
    chk("R8 timer on", 32'(timer_running), 1);
    evt();
    chk("R8 count first", 32'(irq_req), 1);
    // R8 timer wins
    arm(3'd5, 1, 5, 1'b1, 1'b0);
    evt();
    cyc();
    chk("R8 timer pending", 32'(irq_req), 0);
    cyc();
    chk("R8 timer first", 32'(irq_req), 1);

    chk("R14 pidx final", 32'(pidx), 32'(exp_pidx));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule